// File: doc/BRIEF.md
# Next-Instruction Address Unit

This block works out where a 32-bit, word-aligned processor fetches from next. It holds the program counter in a register and presents the current value on `pc_o`. When the front end offers an instruction under `instr_valid_i`, the block decodes the 6-bit opcode in bits 31:26. It also takes the two register operands that have already been read for the rs and rt fields. From these it produces, in the same cycle, the next address, a redirect flag and an illegal-opcode flag. On the following rising clock edge the program counter takes the new address.

Three opcodes change the flow of control. Opcode 4 branches when the two operands are equal. Opcode 5 branches when they differ. Opcode 2 jumps unconditionally. A branch target lies relative to the following instruction and uses the signed 16-bit field in bits 15:0, so a branch can go forward or backward. A jump keeps the upper four bits of the following address and replaces the rest with the 26-bit field in bits 25:0 followed by two zero bits. The processor's register file, ALU, memories and hazard logic sit outside this unit.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0x00000000. After reset is released, `pc_o` stays at 0x00000000 until the first valid instruction.
- R2: A valid instruction whose opcode is not 2, 4 or 5 gives `next_pc_o` = `pc_o` + 4 with `taken_o` = 0.
- R3: Opcode 4 (branch on equal) sets `taken_o` = 1 and selects the branch target when `rs_val_i` == `rt_val_i`.
- R4: Opcode 5 (branch on not equal) sets `taken_o` = 1 and selects the branch target when `rs_val_i` != `rt_val_i`.
- R5: The branch target is `pc_o` + 4 + (sign-extended `instr_i[15:0]` shifted left by 2). A negative field moves backward, and the sum wraps modulo 2^32.
- R6: A branch whose condition fails gives `next_pc_o` = `pc_o` + 4 with `taken_o` = 0.
- R7: Opcode 2 (jump) always sets `taken_o` = 1. Its target is {(`pc_o`+4)[31:28], `instr_i[25:0]`, 2'b00}.
- R8: On a rising edge with `instr_valid_i` high, `pc_o` loads `next_pc_o`. With `instr_valid_i` low, `pc_o` holds its value.
- R9: With `instr_valid_i` low, `taken_o` and `illegal_o` are both 0, whatever `instr_i` holds.
- R10: `illegal_o` is 1 for a valid instruction whose opcode is outside the legal set. The default legal set is {0, 2, 4, 5, 8, 35, 43}. Such an instruction advances to `pc_o` + 4 and is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is offered this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Operand read for the rs field |
| rt_val_i | input | 32 | Operand read for the rt field |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address of the instruction after the current one |
| taken_o | output | 1 | A branch or jump redirects the PC this cycle |
| illegal_o | output | 1 | The valid opcode is outside the legal set |

## Verification
`next_pc_o`, `taken_o` and `illegal_o` are combinational from the inputs and `pc_o`, so they are due in the same cycle as the stimulus. `pc_o` changes only at the next rising edge. The bench drives each instruction just after a falling edge and compares the three combinational results 1 ns later, before the rising edge. It then compares `pc_o` 1 ns after that edge against its own model PC. The model advances only for valid instructions, and that advance sets the expected PC for the following instruction.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JADR_W = 26;
  localparam int unsigned WORD_B = XLEN / 8;
  localparam int unsigned ALGN_W = $clog2(WORD_B);

  localparam logic [OP_W-1:0] OP_JMP = 6'd2;
  localparam logic [OP_W-1:0] OP_BEQ = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE = 6'd5;

  typedef struct packed {
    logic is_beq;
    logic is_bne;
    logic is_jmp;
    logic bad_op;
  } npc_dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter logic [(1<<OP_W)-1:0] LEGAL_OPS = 64'h0000_0808_0000_0135
) (
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output npc_dec_t        dec_o
);
  always_comb begin
    dec_o        = '0;
    dec_o.is_beq = valid_i && (op_i == OP_BEQ);
    dec_o.is_bne = valid_i && (op_i == OP_BNE);
    dec_o.is_jmp = valid_i && (op_i == OP_JMP);
    dec_o.bad_op = valid_i && !LEGAL_OPS[op_i];
  end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         want_eq_i,
  input  logic         want_ne_i,
  output logic         take_o
);
  logic same;
  assign same   = (a_i == b_i);
  assign take_o = (want_eq_i && same) || (want_ne_i && !same);
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JADR_W-1:0] field_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   br_o,
  output logic [XLEN-1:0]   jmp_o
);
  localparam int unsigned SX_W = XLEN - IMM_W - ALGN_W;
  localparam int unsigned HI_W = XLEN - JADR_W - ALGN_W;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  offs;

  assign imm   = field_i[IMM_W-1:0];
  assign offs  = {{SX_W{imm[IMM_W-1]}}, imm, {ALGN_W{1'b0}}};
  assign seq_o = pc_i + XLEN'(WORD_B);
  assign br_o  = seq_o + offs;
  assign jmp_o = {seq_o[XLEN-1 -: HI_W], field_i, {ALGN_W{1'b0}}};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [(1<<OP_W)-1:0] LEGAL_OPS = 64'h0000_0808_0000_0135,
  parameter logic [XLEN-1:0]      RST_PC    = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            illegal_o
);
  npc_dec_t        dec;
  logic            br_take;
  logic [XLEN-1:0] pc_q, seq_pc, br_pc, jmp_pc;

  npc_decode #(.LEGAL_OPS(LEGAL_OPS)) i_dec (
    .valid_i (instr_valid_i),
    .op_i    (instr_i[XLEN-1 -: OP_W]),
    .dec_o   (dec)
  );

  npc_cmp #(.W(XLEN)) i_cmp (
    .a_i       (rs_val_i),
    .b_i       (rt_val_i),
    .want_eq_i (dec.is_beq),
    .want_ne_i (dec.is_bne),
    .take_o    (br_take)
  );

  npc_target i_tgt (
    .pc_i    (pc_q),
    .field_i (instr_i[JADR_W-1:0]),
    .seq_o   (seq_pc),
    .br_o    (br_pc),
    .jmp_o   (jmp_pc)
  );

  always_comb begin
    if (dec.is_jmp)   next_pc_o = jmp_pc;
    else if (br_take) next_pc_o = br_pc;
    else              next_pc_o = seq_pc;
  end

  assign taken_o   = dec.is_jmp || br_take;
  assign illegal_o = dec.bad_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pc_q <= RST_PC;
    else if (instr_valid_i) pc_q <= next_pc_o;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_valid_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            illegal_o
);
  p_rst_pc_r1: assert property (@(posedge clk_i) !rst_ni |-> pc_o == '0);

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(instr_valid_i) |-> pc_o == $past(next_pc_o));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(instr_valid_i) |-> $stable(pc_o));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !taken_o && !illegal_o);

  p_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[31:26] == 6'd2 |-> taken_o);

  p_bad_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !taken_o && next_pc_o == pc_o + 32'd4);

  p_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[31:26] == 6'd4 |-> taken_o == (rs_val_i == rt_val_i));

  p_ne_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[31:26] == 6'd5 |-> taken_o == (rs_val_i != rt_val_i));

  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> next_pc_o == pc_o + 32'd4);
endmodule

bind npc_unit npc_unit_chk i_chk (.*);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] pc_o, next_pc_o;
  logic        taken_o, illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pc = '0;

  always #2 clk_i = ~clk_i;

  npc_unit i_npc_unit (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
    end
  endtask

  function automatic logic legal(input int op);
    return op == 0 || op == 2 || op == 4 || op == 5 || op == 8 || op == 35 || op == 43;
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    int          op;
    logic [31:0] nxt, e_next;
    logic        e_tk, e_il;
    @(negedge clk_i);
    instr_valid_i = v; instr_i = ins; rs_val_i = a; rt_val_i = b;
    op   = int'(ins[31:26]);
    nxt  = m_pc + 4;
    e_tk = 1'b0;
    e_il = v && !legal(op);
    e_next = nxt;
    if (v && op == 2) begin
      e_tk = 1'b1; e_next = {nxt[31:28], ins[25:0], 2'b00};
    end else if (v && ((op == 4 && a == b) || (op == 5 && a != b))) begin
      e_tk = 1'b1; e_next = nxt + (32'(signed'(ins[15:0])) * 4);
    end
    #1;
    chk(tag, "next_pc", next_pc_o, e_next);
    chk(tag, "taken", 32'(taken_o), 32'(e_tk));
    chk(tag, "illegal", 32'(illegal_o), 32'(e_il));
    @(posedge clk_i); #1;
    if (v) m_pc = e_next;
    chk(v ? "R8 load" : "R8 hold", "pc", pc_o, m_pc);
  endtask

  function automatic logic [31:0] itype(input int op, input logic [15:0] imm);
    return {6'(op), 5'd1, 5'd2, imm};
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk("R1", "pc in reset", pc_o, 32'h0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", "pc after release", pc_o, 32'h0);
    step(1, itype(8, 16'h0005), 1, 2, "R2 addi");
    step(1, {6'd0, 26'h123456}, 1, 2, "R2 rtype");
    step(1, itype(4, 16'h0003), 32'hAA, 32'hAA, "R3 R5 beq fwd");
    step(1, itype(4, 16'h0003), 32'hAA, 32'hAB, "R6 beq miss");
    step(1, itype(5, 16'hFFFA), 7, 9, "R4 R5 bne back");
    step(1, itype(5, 16'hFFFA), 9, 9, "R6 bne miss");
    step(1, {6'd2, 26'h0000040}, 0, 0, "R7 jump");
    step(0, {6'd2, 26'h3FFFFFF}, 0, 0, "R9 no valid jump");
    step(0, itype(4, 16'h0010), 3, 3, "R9 no valid beq");
    step(0, itype(63, 16'h0), 0, 0, "R9 no valid bad");
    step(1, itype(63, 16'h0010), 0, 0, "R10 bad op");
    step(1, itype(1, 16'h0010), 4, 4, "R10 bad op1");
    step(1, itype(4, 16'h8000), 5, 5, "R5 wrap back");
    step(1, {6'd2, 26'h2AAAAAA}, 0, 0, "R7 jump high");
    step(1, itype(35, 16'h0020), 0, 0, "R2 load");
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    m_pc = '0;
    chk("R1", "pc async reset", pc_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, itype(5, 16'h0001), 1, 0, "R4 after reset");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule